// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a processor core and a data memory that is 32 bits wide and addressed by words. It takes one access at a time. For a store it receives a size code, a byte address and the register value. It turns these into a word address, a contiguous group of byte write enables and write data whose enabled byte lanes carry the value. For a load it selects the requested byte, halfword or word from the returned memory word. It then extends the result to 32 bits, with sign or with zeros as the size code demands.

Control is a three-state machine. `ST_IDLE` accepts a request (`req_valid` while `req_ready`). A legal, aligned request goes from `ST_IDLE` to `ST_ACCESS`. An illegal or misaligned request goes directly to `ST_RESP` and never reaches memory. `ST_ACCESS` holds the memory request until `mem_ack` and then goes to `ST_RESP`. `ST_RESP` presents the response for exactly one cycle and returns to `ST_IDLE`.

Size codes are funct3 values. Loads use 0 (signed byte), 1 (signed halfword), 2 (word), 4 (unsigned byte) and 5 (unsigned halfword). Stores use 0 (byte), 1 (halfword) and 2 (word). The caller computes the effective address; this unit neither computes it nor splits an access.

Top module: `lsu_lane_align`

## Requirements
- R1: A legal aligned store drives `mem_we`=1 and `mem_addr` = byte address >> 2. `mem_be` is 4'b0001 (size 0), 4'b0011 (size 1) or 4'b1111 (size 2), shifted left by the address bits [1:0].
- R2: On a store, byte lane j of `mem_wdata`, when enabled, carries byte (j - offset) of `req_wdata`.
- R3: A load with size 0 or 1 returns the byte or halfword at the addressed offset, sign-extended to 32 bits.
- R4: A load with size 4 or 5 returns the field zero-extended. A load with size 2 returns the whole word unchanged.
- R5: A halfword access at an odd address, or a word access whose address bits [1:0] are not 00, responds in the cycle after acceptance with `rsp_misaligned`=1 and issues no memory request.
- R6: Load size codes 3, 6 and 7, and store size codes 3 to 7, respond in the cycle after acceptance with `rsp_illegal`=1, `rsp_misaligned`=0 and no memory request.
- R7: The memory request and its address, enables, data and direction stay unchanged until `mem_ack`. The response, including the extended load result, is valid in the cycle after the cycle in which `mem_ack` is high.
- R8: Only one access is in flight. `req_ready` is high only in the idle state, and `rsp_valid` lasts exactly one cycle before `req_ready` returns.
- R9: During and right after reset, `req_ready`=1, `mem_req`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Unit idle, request accepted |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | funct3 size code |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store value (low bits used for narrow stores) |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_ack | input | 1 | Memory completes the access |
| mem_rdata | input | 32 | Memory read word, valid with `mem_ack` |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_rdata | output | 32 | Extended load result, zero otherwise |
| rsp_misaligned | output | 1 | Access was misaligned |
| rsp_illegal | output | 1 | Size code not legal for the direction |

## Verification
Stores of every width are tried at every legal lane offset. Later loads then read the same bytes back, which shows whether enables and lane steering match, since a wrong lane corrupts a byte the reference memory still holds. Each load width is tried on bytes whose top bit is set and on bytes whose top bit is clear, so that sign extension can be told apart from zero extension. Misaligned and illegal codes are mixed, including an illegal code at an odd address, which shows whether illegal takes precedence. Memory latencies of zero to three wait cycles show whether the request is held and whether the response comes one cycle after the acknowledge.

// File: rtl/lsu_align_pkg.sv
`timescale 1ns/1ps
package lsu_align_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_RESP   = 2'd2
    } lsu_state_e;

    // funct3 size codes
    localparam logic [2:0] SZ_B  = 3'd0;
    localparam logic [2:0] SZ_H  = 3'd1;
    localparam logic [2:0] SZ_W  = 3'd2;
    localparam logic [2:0] SZ_BU = 3'd4;
    localparam logic [2:0] SZ_HU = 3'd5;

endpackage

// File: rtl/lsu_access_check.sv
`timescale 1ns/1ps
module lsu_access_check
    import lsu_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic             is_store,
    input  logic [2:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic             illegal,
    output logic             misaligned
);
    logic is_half;
    logic is_word;

    always_comb begin
        if (is_store) begin
            illegal = !(size inside {SZ_B, SZ_H, SZ_W});
        end else begin
            illegal = !(size inside {SZ_B, SZ_H, SZ_W, SZ_BU, SZ_HU});
        end
        is_half    = (size == SZ_H) || (size == SZ_HU);
        is_word    = (size == SZ_W);
        // illegal has priority: misaligned only reported for legal codes
        misaligned = !illegal && ((is_half && off[0]) || (is_word && (off != '0)));
    end
endmodule

// File: rtl/lsu_store_steer.sv
`timescale 1ns/1ps
module lsu_store_steer
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANES = DATA_W / 8,
    localparam int OFF_W  = $clog2(NLANES)
) (
    input  logic [2:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [NLANES-1:0] be,
    output logic [DATA_W-1:0] wdata_out
);
    logic [NLANES-1:0] base_mask;

    always_comb begin
        unique case (size)
            SZ_B:    base_mask = NLANES'(1);
            SZ_H:    base_mask = NLANES'(3);
            default: base_mask = '1;
        endcase
        be = base_mask << off;
    end

    // Byte is replicated on every lane, halfword on every lane pair.
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        assign wdata_out[8*i +: 8] =
            (size == SZ_B) ? wdata_in[7:0] :
            (size == SZ_H) ? wdata_in[8*(i%2) +: 8] :
                             wdata_in[8*i +: 8];
    end
endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANES = DATA_W / 8,
    localparam int OFF_W  = $clog2(NLANES)
) (
    input  logic [2:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = word >> {off, 3'b000};
        unique case (size)
            SZ_B:    result = {{(DATA_W-8){shifted[7]}}, shifted[7:0]};
            SZ_H:    result = {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
            SZ_BU:   result = {{(DATA_W-8){1'b0}}, shifted[7:0]};
            SZ_HU:   result = {{(DATA_W-16){1'b0}}, shifted[15:0]};
            default: result = shifted;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
`timescale 1ns/1ps
module lsu_lane_align
    import lsu_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int NLANES = DATA_W / 8,
    localparam int OFF_W  = $clog2(NLANES),
    localparam int WADR_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_store,
    input  logic [2:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WADR_W-1:0] mem_addr,
    output logic [NLANES-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_misaligned,
    output logic              rsp_illegal
);
    lsu_state_e state_q, state_d;

    logic [OFF_W-1:0]  in_off;
    logic              in_illegal, in_misaligned;
    logic [NLANES-1:0] in_be;
    logic [DATA_W-1:0] in_wdata;

    logic              store_q, ill_q, mis_q;
    logic [2:0]        size_q;
    logic [OFF_W-1:0]  off_q;
    logic [WADR_W-1:0] waddr_q;
    logic [NLANES-1:0] be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rword_q;
    logic [DATA_W-1:0] ext_result;
    logic              accept;

    assign in_off = req_addr[OFF_W-1:0];
    assign accept = (state_q == ST_IDLE) && req_valid;

    lsu_access_check #(.OFF_W(OFF_W)) chk_i (
        .is_store   (req_is_store),
        .size       (req_size),
        .off        (in_off),
        .illegal    (in_illegal),
        .misaligned (in_misaligned)
    );

    lsu_store_steer #(.DATA_W(DATA_W)) steer_i (
        .size      (req_size),
        .off       (in_off),
        .wdata_in  (req_wdata),
        .be        (in_be),
        .wdata_out (in_wdata)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) extract_i (
        .size   (size_q),
        .off    (off_q),
        .word   (rword_q),
        .result (ext_result)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (in_illegal || in_misaligned) ? ST_RESP : ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (mem_ack) begin
                    state_d = ST_RESP;
                end
            end
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture and read word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            ill_q   <= 1'b0;
            mis_q   <= 1'b0;
            size_q  <= '0;
            off_q   <= '0;
            waddr_q <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rword_q <= '0;
        end else begin
            if (accept) begin
                store_q <= req_is_store;
                ill_q   <= in_illegal;
                mis_q   <= in_misaligned;
                size_q  <= req_size;
                off_q   <= in_off;
                waddr_q <= req_addr[ADDR_W-1:OFF_W];
                be_q    <= in_be;
                wdata_q <= in_wdata;
            end
            if ((state_q == ST_ACCESS) && mem_ack && !store_q) begin
                rword_q <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_ACCESS: mem_req   = 1'b1;
            ST_RESP:   rsp_valid = 1'b1;
            default: ;
        endcase
        mem_we         = mem_req && store_q;
        mem_addr       = mem_req ? waddr_q : '0;
        mem_be         = mem_we ? be_q : '0;
        mem_wdata      = mem_we ? wdata_q : '0;
        rsp_misaligned = rsp_valid && mis_q;
        rsp_illegal    = rsp_valid && ill_q;
        rsp_rdata      = (rsp_valid && !store_q && !mis_q && !ill_q) ? ext_result : '0;
    end
endmodule

// File: rtl/lsu_lane_align_sva.sv
`timescale 1ns/1ps
module lsu_lane_align_sva #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int NLANES = DATA_W / 8,
    localparam int OFF_W  = $clog2(NLANES),
    localparam int WADR_W = ADDR_W - OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WADR_W-1:0] mem_addr,
    input logic [NLANES-1:0] mem_be,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              rsp_valid,
    input logic              rsp_misaligned,
    input logic              rsp_illegal
);
    a_r1_be_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (($countones(mem_be) == 1) || (mem_be == NLANES'(3)) ||
                    (mem_be == NLANES'(12)) || (mem_be == '1)));

    a_r5_fault_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_misaligned) |-> ($past(req_valid && req_ready) && $past(!mem_req)));

    a_r6_illegal_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (!rsp_misaligned && $past(req_valid && req_ready)));

    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) &&
                                   $stable(mem_be) && $stable(mem_wdata)));

    a_r7_resp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (rsp_valid && !rsp_misaligned && !rsp_illegal));

    a_r8_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    a_r8_exclusive_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_req, rsp_valid}));
endmodule

bind lsu_lane_align lsu_lane_align_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) sva_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_be         (mem_be),
    .mem_wdata      (mem_wdata),
    .mem_ack        (mem_ack),
    .rsp_valid      (rsp_valid),
    .rsp_misaligned (rsp_misaligned),
    .rsp_illegal    (rsp_illegal)
);

// File: tb/lsu_lane_align_tb.sv
`timescale 1ns/1ps
module lsu_lane_align_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_store = 1'b0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_req, mem_we;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_misaligned, rsp_illegal;

    int checks = 0;
    int failures = 0;
    logic [7:0] mb [0:63];   // reference byte memory

    always #2.5 clk = ~clk;

    lsu_lane_align dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_misaligned(rsp_misaligned), .rsp_illegal(rsp_illegal)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(input logic [2:0] sz, input int a);
        int v;
        bit sgn;
        sgn = (sz == 3'd0) || (sz == 3'd1);
        if (sz == 3'd0 || sz == 3'd4) begin
            v = int'(mb[a]);
            if (sgn && v >= 128) v = v - 256;
        end else if (sz == 3'd1 || sz == 3'd5) begin
            v = int'(mb[a]) + 256 * int'(mb[a+1]);
            if (sgn && v >= 32768) v = v - 65536;
        end else begin
            v = int'({mb[a+3], mb[a+2], mb[a+1], mb[a]});
        end
        return 32'(v);
    endfunction

    task automatic do_op(input bit st, input logic [2:0] sz, input int a,
                         input logic [31:0] wd, input int lat);
        int off, nb, w;
        bit ill, mis;
        logic [31:0] exp_rd;
        logic [3:0] exp_be;
        off = a % 4;
        w   = a / 4;
        ill = st ? (sz > 3'd2) : !(sz inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5});
        nb  = (sz[1:0] == 2'd0) ? 1 : (sz[1:0] == 2'd1) ? 2 : 4;
        mis = !ill && ((a % nb) != 0);
        exp_rd = (!st && !ill && !mis) ? ref_load(sz, a) : 32'h0;
        exp_be = 4'((((1 << nb) - 1) << off));

        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready when idle", 32'(req_ready), 32'h1);
        req_valid = 1'b1; req_is_store = st; req_size = sz;
        req_addr = 32'(a); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (ill || mis) begin
            chk(rsp_valid == 1'b1, ill ? "R6 fault response" : "R5 fault response", 32'(rsp_valid), 32'h1);
            chk(rsp_illegal == ill, "R6 illegal flag", 32'(rsp_illegal), 32'(ill));
            chk(rsp_misaligned == mis, "R5 misaligned flag", 32'(rsp_misaligned), 32'(mis));
            chk(mem_req == 1'b0, ill ? "R6 no memory access" : "R5 no memory access", 32'(mem_req), 32'h0);
        end else begin
            for (int k = 0; k <= lat; k++) begin
                chk(mem_req == 1'b1, "R7 request held", 32'(mem_req), 32'h1);
                chk(rsp_valid == 1'b0, "R7 no early response", 32'(rsp_valid), 32'h0);
                chk(mem_we == st, "R1 write direction", 32'(mem_we), 32'(st));
                chk(mem_addr == 30'(w), "R1 word address", 32'(mem_addr), 32'(w));
                if (st) begin
                    chk(mem_be == exp_be, "R1 byte enables", 32'(mem_be), 32'(exp_be));
                    for (int j = 0; j < 4; j++) begin
                        if (j >= off && j < off + nb) begin
                            chk(mem_wdata[8*j +: 8] == wd[8*(j-off) +: 8], "R2 lane data",
                                32'(mem_wdata[8*j +: 8]), 32'(wd[8*(j-off) +: 8]));
                        end
                    end
                end
                if (k == lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = {mb[4*w+3], mb[4*w+2], mb[4*w+1], mb[4*w]};
                    if (st) begin
                        for (int j = 0; j < nb; j++) mb[a+j] = wd[8*j +: 8];
                    end
                end
                @(negedge clk);
                mem_ack = 1'b0;
                mem_rdata = 32'h0;
            end
            chk(rsp_valid == 1'b1, "R7 response after ack", 32'(rsp_valid), 32'h1);
            chk(!rsp_misaligned && !rsp_illegal, "R7 no fault flags",
                32'({rsp_misaligned, rsp_illegal}), 32'h0);
            if (!st) begin
                chk(rsp_rdata == exp_rd,
                    ((sz == 3'd0) || (sz == 3'd1)) ? "R3 sign-extended load" : "R4 zero-ext or word load",
                    rsp_rdata, exp_rd);
            end
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 one-cycle response", 32'(rsp_valid), 32'h0);
        chk(req_ready == 1'b1, "R8 ready returns", 32'(req_ready), 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mb[i] = 8'((i * 37 + 11) ^ ((i & 1) ? 8'h80 : 8'h00));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 32'h1);
        chk(mem_req == 1'b0, "R9 no request in reset", 32'(mem_req), 32'h0);
        chk(rsp_valid == 1'b0, "R9 no response in reset", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0 && rsp_valid == 1'b0, "R9 idle after reset",
            32'({mem_req, rsp_valid}), 32'h0);

        // stores of each width at each legal offset
        do_op(1'b1, 3'd2, 16, 32'hDEADBEEF, 0);
        do_op(1'b1, 3'd0, 20, 32'h1234_5681, 1);
        do_op(1'b1, 3'd0, 21, 32'hFFFF_FF7E, 0);
        do_op(1'b1, 3'd0, 22, 32'h0000_00C3, 2);
        do_op(1'b1, 3'd0, 23, 32'hAAAA_AA05, 0);
        do_op(1'b1, 3'd1, 24, 32'h5555_8001, 3);
        do_op(1'b1, 3'd1, 26, 32'h0000_7FFE, 1);

        // loads of every width and signedness, sign bit set and clear
        for (int o = 0; o < 4; o++) begin
            do_op(1'b0, 3'd0, 20 + o, 32'h0, o % 3);
            do_op(1'b0, 3'd4, 20 + o, 32'h0, 0);
        end
        do_op(1'b0, 3'd1, 24, 32'h0, 0);
        do_op(1'b0, 3'd1, 26, 32'h0, 2);
        do_op(1'b0, 3'd5, 24, 32'h0, 1);
        do_op(1'b0, 3'd5, 26, 32'h0, 0);
        do_op(1'b0, 3'd2, 16, 32'h0, 3);
        do_op(1'b0, 3'd2, 20, 32'h0, 0);
        do_op(1'b0, 3'd0, 5, 32'h0, 0);
        do_op(1'b0, 3'd1, 8, 32'h0, 1);

        // misaligned
        do_op(1'b0, 3'd1, 17, 32'h0, 0);
        do_op(1'b0, 3'd5, 19, 32'h0, 0);
        do_op(1'b0, 3'd2, 18, 32'h0, 0);
        do_op(1'b0, 3'd2, 13, 32'h0, 0);
        do_op(1'b1, 3'd1, 3, 32'h1111_2222, 0);
        do_op(1'b1, 3'd2, 30, 32'h3333_4444, 0);
        do_op(1'b1, 3'd2, 41, 32'h3333_4444, 0);

        // illegal codes, including one at an odd address
        do_op(1'b0, 3'd3, 16, 32'h0, 0);
        do_op(1'b0, 3'd6, 17, 32'h0, 0);
        do_op(1'b0, 3'd7, 20, 32'h0, 0);
        for (int c = 3; c < 8; c++) do_op(1'b1, 3'(c), 33, 32'hCAFE_F00D, 0);

        // the faulting stores left memory untouched
        do_op(1'b0, 3'd2, 0, 32'h0, 0);
        do_op(1'b0, 3'd2, 28, 32'h0, 1);
        do_op(1'b0, 3'd2, 32, 32'h0, 0);
        do_op(1'b0, 3'd2, 40, 32'h0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule